// File: doc/BRIEF.md
# Wormhole Crossbar Output Allocator

This block assigns the output ports of a wormhole switch to its input ports and carries flits from each input to its assigned output. Each input that has a packet header waiting raises a request together with the number of the output it wants; the number comes from the routing byte at the front of the packet. One shared arbiter looks at exactly one waiting header per clock cycle. It picks the next requesting input in cyclic order, starting just after the input it looked at last. An input with no request uses up no arbitration cycle.

If the wanted output is free, the arbiter grants it. The output then belongs to that input until the packet's final flit has crossed. If the output is in use, the header stays where it is and is tried again only when the cyclic order reaches that input again. No queue is kept at the output. After a grant, the input must wait a fixed header-forwarding latency before its first flit can flow. From then on, one byte-wide flit crosses per cycle through a plain multiplexer crossbar, and any number of input/output pairs can be active at the same time. A sideband last-flit marker on each input frees the output.

Top module: `wh_xbar_alloc`

## Requirements
- R1: After reset no grant is issued, every output is free, no input is ready and no output presents a valid flit.
- R2: At most one grant is issued in any cycle.
- R3: The arbiter examines the first input, in cyclic order starting one past the last input examined, that has a request and no active connection. Right after reset the search starts at input 0. Inputs without a request are passed over within the same cycle.
- R4: If the examined input's requested output is busy, no grant is issued in that cycle. The search pointer still moves past that input, and the input is examined again when the cyclic order next reaches it.
- R5: A grant is issued only for a free output (grant bit i corresponds to input i, and the destination field of input i is bits [i*2+1:i*2] for 4 ports). The output then stays busy until its owner's last flit is accepted.
- R6: An input's ready signal rises exactly HDR_LAT cycles (default 24) after the cycle in which its grant is high.
- R7: While an input is ready, the flit it presents appears on its assigned output in the same cycle, along with its valid and last markers, at one byte per cycle.
- R8: Once a flit marked last has been accepted, the output is free and the input is no longer ready in the next cycle.
- R9: Several connected input/output pairs forward flits in the same cycle without interfering.
- R10: An output that is free, or whose owner is not yet ready, presents no valid flit, whatever the inputs drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_PORTS | Header waiting at input i |
| req_dst | input | N_PORTS*DST_W | Requested output number, one field per input |
| flit_data | input | N_PORTS*FLIT_W | Flit byte from each input |
| flit_valid | input | N_PORTS | Flit present at input i |
| flit_last | input | N_PORTS | Flit at input i is the tail |
| grant | output | N_PORTS | Header of input i granted this cycle |
| in_ready | output | N_PORTS | Input i may forward flits |
| out_data | output | N_PORTS*FLIT_W | Flit byte on each output |
| out_valid | output | N_PORTS | Output o carries a flit |
| out_last | output | N_PORTS | Flit on output o is the tail |
| out_busy | output | N_PORTS | Output o is allocated |

## Verification
A single lone request checks the grant path, the exact forwarding latency, flit transfer and the release on the tail. All four inputs requesting distinct outputs at once shows the cyclic order, one grant per cycle. Two inputs asking for the same output, and a request that lands on an output already in use, show that the losing header is skipped rather than queued, that the pointer still moves, and that the header wins on a later turn after the release. Two connections streaming in the same cycles show that flits cross without interference. Flits driven before ready is reached show that nothing leaks onto a held output early.

// File: rtl/wxa_pkg.sv
package wxa_pkg;
  // next index in cyclic order over n entries
  function automatic int unsigned wrap_inc(input int unsigned idx, input int unsigned n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

  // index visited at step k when the scan starts at base
  function automatic int unsigned scan_at(input int unsigned base, input int unsigned k,
                                          input int unsigned n);
    return (base + k) % n;
  endfunction

  // width of a counter able to hold value v
  function automatic int unsigned cnt_width(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction
endpackage

// File: rtl/wxa_rr_scan.sv
module wxa_rr_scan #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     elig,
  input  logic [IDX_W-1:0] base,
  output logic             found,
  output logic [IDX_W-1:0] pick
);
  import wxa_pkg::*;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 0; k < N; k++) begin
      int unsigned cand;
      cand = scan_at(int'(base), k, N);
      if (!found && elig[cand]) begin
        found = 1'b1;
        pick  = IDX_W'(cand);
      end
    end
  end
endmodule

// File: rtl/wxa_in_port.sv
module wxa_in_port #(
  parameter int DST_W   = 2,
  parameter int HDR_LAT = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [DST_W-1:0] dst_in,
  input  logic             fv,
  input  logic             fl,
  output logic             linked,
  output logic [DST_W-1:0] link_port,
  output logic             ready,
  output logic             tail_fire
);
  import wxa_pkg::*;
  localparam int LAT_W = cnt_width(HDR_LAT);
  localparam logic [LAT_W-1:0] LOAD = LAT_W'(HDR_LAT - 1);

  logic [LAT_W-1:0] wait_cnt;

  assign ready     = linked && (wait_cnt == '0);
  assign tail_fire = ready && fv && fl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      linked    <= 1'b0;
      link_port <= '0;
      wait_cnt  <= '0;
    end else if (take) begin
      linked    <= 1'b1;
      link_port <= dst_in;
      wait_cnt  <= LOAD;
    end else if (tail_fire) begin
      linked    <= 1'b0;
      wait_cnt  <= '0;
    end else if (linked && wait_cnt != '0) begin
      wait_cnt  <= wait_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/wxa_xbar.sv
module wxa_xbar #(
  parameter int N     = 4,
  parameter int FW    = 8,
  parameter int DST_W = 2
) (
  input  logic [N-1:0]       busy,
  input  logic [N*DST_W-1:0] owner,
  input  logic [N*FW-1:0]    in_data,
  input  logic [N-1:0]       in_valid,
  input  logic [N-1:0]       in_last,
  input  logic [N-1:0]       in_ready,
  output logic [N*FW-1:0]    o_data,
  output logic [N-1:0]       o_valid,
  output logic [N-1:0]       o_last
);
  for (genvar o = 0; o < N; o++) begin : g_out
    logic [DST_W-1:0] src;
    logic             live;
    assign src  = owner[o*DST_W +: DST_W];
    assign live = busy[o] && in_ready[src] && in_valid[src];
    assign o_valid[o]          = live;
    assign o_last[o]           = live && in_last[src];
    assign o_data[o*FW +: FW]  = live ? in_data[int'(src)*FW +: FW] : '0;
  end
endmodule

// File: rtl/wh_xbar_alloc.sv
module wh_xbar_alloc #(
  parameter int N_PORTS = 4,
  parameter int FLIT_W  = 8,
  parameter int HDR_LAT = 24,
  parameter int DST_W   = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_PORTS-1:0]          req_valid,
  input  logic [N_PORTS*DST_W-1:0]    req_dst,
  input  logic [N_PORTS*FLIT_W-1:0]   flit_data,
  input  logic [N_PORTS-1:0]          flit_valid,
  input  logic [N_PORTS-1:0]          flit_last,
  output logic [N_PORTS-1:0]          grant,
  output logic [N_PORTS-1:0]          in_ready,
  output logic [N_PORTS*FLIT_W-1:0]   out_data,
  output logic [N_PORTS-1:0]          out_valid,
  output logic [N_PORTS-1:0]          out_last,
  output logic [N_PORTS-1:0]          out_busy
);
  import wxa_pkg::*;

  // named internal events
  logic [N_PORTS-1:0]       linked_vec;
  logic [N_PORTS-1:0]       elig_vec;
  logic [N_PORTS-1:0]       tail_vec;
  logic [N_PORTS*DST_W-1:0] link_ports;
  logic [N_PORTS*DST_W-1:0] owner_tbl;
  logic [DST_W-1:0]         rr_ptr;
  logic                     arb_found;
  logic [DST_W-1:0]         arb_idx;
  logic [DST_W-1:0]         arb_dst;
  logic                     arb_win;
  logic                     arb_skip;

  assign elig_vec = req_valid & ~linked_vec;

  wxa_rr_scan #(.N(N_PORTS), .IDX_W(DST_W)) u_scan (
    .elig  (elig_vec),
    .base  (rr_ptr),
    .found (arb_found),
    .pick  (arb_idx)
  );

  assign arb_dst  = req_dst[int'(arb_idx)*DST_W +: DST_W];
  assign arb_win  = arb_found && !out_busy[arb_dst];
  assign arb_skip = arb_found && out_busy[arb_dst];

  always_comb begin
    grant = '0;
    if (arb_win) grant[arb_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         rr_ptr <= '0;
    else if (arb_found) rr_ptr <= DST_W'(wrap_inc(int'(arb_idx), N_PORTS));
  end

  for (genvar i = 0; i < N_PORTS; i++) begin : g_in
    wxa_in_port #(.DST_W(DST_W), .HDR_LAT(HDR_LAT)) u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (grant[i]),
      .dst_in    (req_dst[i*DST_W +: DST_W]),
      .fv        (flit_valid[i]),
      .fl        (flit_last[i]),
      .linked    (linked_vec[i]),
      .link_port (link_ports[i*DST_W +: DST_W]),
      .ready     (in_ready[i]),
      .tail_fire (tail_vec[i])
    );
  end

  // ownership of each output
  for (genvar o = 0; o < N_PORTS; o++) begin : g_own
    logic [DST_W-1:0] who;
    logic             rel;
    assign who = owner_tbl[o*DST_W +: DST_W];
    assign rel = out_busy[o] && tail_vec[who] &&
                 (link_ports[int'(who)*DST_W +: DST_W] == DST_W'(o));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        out_busy[o]                  <= 1'b0;
        owner_tbl[o*DST_W +: DST_W]  <= '0;
      end else if (arb_win && arb_dst == DST_W'(o)) begin
        out_busy[o]                  <= 1'b1;
        owner_tbl[o*DST_W +: DST_W]  <= arb_idx;
      end else if (rel) begin
        out_busy[o]                  <= 1'b0;
      end
    end
  end

  wxa_xbar #(.N(N_PORTS), .FW(FLIT_W), .DST_W(DST_W)) u_xbar (
    .busy     (out_busy),
    .owner    (owner_tbl),
    .in_data  (flit_data),
    .in_valid (flit_valid),
    .in_last  (flit_last),
    .in_ready (in_ready),
    .o_data   (out_data),
    .o_valid  (out_valid),
    .o_last   (out_last)
  );
endmodule

// File: rtl/wxa_chk.sv
module wxa_chk #(
  parameter int N       = 4,
  parameter int HDR_LAT = 24,
  parameter int DST_W   = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N-1:0]     grant,
  input logic [N-1:0]     in_ready,
  input logic [N-1:0]     out_busy,
  input logic [N-1:0]     out_valid,
  input logic [N-1:0]     tail_vec,
  input logic             arb_found,
  input logic [DST_W-1:0] arb_idx,
  input logic [DST_W-1:0] rr_ptr
);
  import wxa_pkg::*;
  localparam int AGE_W = cnt_width(HDR_LAT + 2);

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R2

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    arb_found |=> rr_ptr == DST_W'(wrap_inc(int'($past(arb_idx)), N))); // R3

  AST_PTR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_found |=> $stable(rr_ptr)); // R4

  for (genvar o = 0; o < N; o++) begin : g_o
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !out_busy[o] |-> !out_valid[o]); // R10
    AST_HELD_TO_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
      (out_busy[o] && tail_vec == '0) |=> out_busy[o]); // R5
  end

  for (genvar i = 0; i < N; i++) begin : g_i
    logic [AGE_W-1:0] age;
    always_ff @(posedge clk) begin
      if (!rst_n)                   age <= '0;
      else if (grant[i])            age <= AGE_W'(1);
      else if (age != '1)           age <= age + 1'b1;
    end
    AST_READY_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_ready[i]) |-> age == AGE_W'(HDR_LAT)); // R6
    AST_TAIL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      tail_vec[i] |=> !in_ready[i]); // R8
    AST_GRANT_UNLINKED: assert property (@(posedge clk) disable iff (!rst_n)
      grant[i] |-> !in_ready[i]); // R5
  end
endmodule

bind wh_xbar_alloc wxa_chk #(.N(N_PORTS), .HDR_LAT(HDR_LAT), .DST_W(DST_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .grant     (grant),
  .in_ready  (in_ready),
  .out_busy  (out_busy),
  .out_valid (out_valid),
  .tail_vec  (tail_vec),
  .arb_found (arb_found),
  .arb_idx   (arb_idx),
  .rr_ptr    (rr_ptr)
);

// File: tb/sim_wh_xbar_alloc.sv
module sim_wh_xbar_alloc;
  localparam int N   = 4;
  localparam int FW  = 8;
  localparam int LAT = 24;
  localparam int DW  = 2;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [N-1:0]    req_valid;
  logic [N*DW-1:0] req_dst;
  logic [N*FW-1:0] flit_data;
  logic [N-1:0]    flit_valid, flit_last;
  logic [N-1:0]    grant, in_ready, out_valid, out_last, out_busy;
  logic [N*FW-1:0] out_data;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  always #4 clk = ~clk;

  wh_xbar_alloc #(.N_PORTS(N), .FLIT_W(FW), .HDR_LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dst(req_dst),
    .flit_data(flit_data), .flit_valid(flit_valid), .flit_last(flit_last),
    .grant(grant), .in_ready(in_ready), .out_data(out_data),
    .out_valid(out_valid), .out_last(out_last), .out_busy(out_busy)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic ask(input int i, input int d);
    req_valid[i] = 1'b1;
    req_dst[i*DW +: DW] = DW'(d);
  endtask

  task automatic flit(input int i, input int v, input int d, input int l);
    flit_valid[i] = v[0];
    flit_data[i*FW +: FW] = FW'(d);
    flit_last[i] = l[0];
  endtask

  function automatic int odata(input int o);
    return int'(out_data[o*FW +: FW]);
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    req_valid = '0; req_dst = '0;
    flit_data = '0; flit_valid = '0; flit_last = '0;
    nxt(); nxt();
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk("R1 grant", int'(grant), 0);
    chk("R1 busy", int'(out_busy), 0);
    chk("R1 ready", int'(in_ready), 0);
    chk("R1 out_valid", int'(out_valid), 0);
  endtask

  task automatic t_single();
    nxt(); ask(1, 2); #1;
    chk("R3 first grant input1", int'(grant), 4'b0010);
    nxt(); req_valid[1] = 1'b0; flit(1, 1, 8'hEE, 0); #1;
    chk("R5 output2 busy", int'(out_busy), 4'b0100);
    chk("R10 no early flit", int'(out_valid), 0);
    for (int k = 2; k <= LAT; k++) begin
      nxt(); #1;
      if (k == LAT - 1) chk("R6 not ready yet", int'(in_ready[1]), 0);
      if (k == LAT) begin
        chk("R6 ready on time", int'(in_ready[1]), 1);
        chk("R7 flit valid", int'(out_valid), 4'b0100);
        chk("R7 flit data", odata(2), 8'hEE);
      end
    end
    nxt(); flit(1, 1, 8'h11, 0); #1;
    chk("R7 second flit", odata(2), 8'h11);
    nxt(); flit(1, 1, 8'h22, 1); #1;
    chk("R7 tail marker", int'(out_last), 4'b0100);
    nxt(); flit(1, 0, 0, 0); #1;
    chk("R8 output freed", int'(out_busy), 0);
    chk("R8 ready dropped", int'(in_ready[1]), 0);
  endtask

  task automatic t_busy_skip();
    nxt(); ask(0, 3); #1;
    chk("R3 wrap to input0", int'(grant), 4'b0001);
    nxt(); req_valid[0] = 1'b0; ask(2, 3); ask(3, 1); #1;
    chk("R4 busy output skipped", int'(grant), 0);
    nxt(); #1;
    chk("R3 next turn input3", int'(grant), 4'b1000);
    nxt(); req_valid[3] = 1'b0; #1;
    chk("R4 retry still busy", int'(grant), 0);
    repeat (23) nxt();
    #1;
    chk("R6 both ready", int'(in_ready), 4'b1001);
    flit(0, 1, 8'hA5, 0); flit(3, 1, 8'h3C, 0); #1;
    chk("R9 both valid", int'(out_valid), 4'b1010);
    chk("R9 out3 data", odata(3), 8'hA5);
    chk("R9 out1 data", odata(1), 8'h3C);
    nxt(); flit(0, 1, 8'h5A, 1); flit(3, 1, 8'h77, 0); #1;
    chk("R9 out3 tail", int'(out_last), 4'b1000);
    chk("R9 out1 data 2", odata(1), 8'h77);
    nxt(); flit(0, 0, 0, 0); flit(3, 0, 0, 0); #1;
    chk("R4 skipped header wins later", int'(grant), 4'b0100);
    chk("R8 only output1 held", int'(out_busy), 4'b0010);
  endtask

  task automatic t_order();
    do_reset();
    ask(3, 0); #1;
    chk("R3 idle inputs take no slot", int'(grant), 4'b1000);
    do_reset();
    ask(0, 3); ask(1, 2); ask(2, 1); ask(3, 0);
    for (int c = 0; c < N; c++) begin
      #1;
      chk("R3 cyclic order", int'(grant), 1 << c);
      nxt(); req_valid[c] = 1'b0;
    end
    #1;
    chk("R5 all outputs held", int'(out_busy), 4'b1111);
  endtask

  task automatic t_conflict();
    do_reset();
    ask(0, 2); ask(1, 2); #1;
    chk("R2 one of two wins", int'(grant), 4'b0001);
    nxt(); req_valid[0] = 1'b0; #1;
    chk("R4 loser skipped", int'(grant), 0);
    repeat (5) nxt();
    #1;
    chk("R4 loser keeps waiting", int'(grant), 0);
    chk("R5 held until tail", int'(out_busy), 4'b0100);
    flit(1, 1, 8'h99, 0); #1;
    chk("R10 waiting input not forwarded", int'(out_valid), 0);
    flit(1, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_single();
    t_busy_skip();
    t_order();
    t_conflict();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule